// File: doc/BRIEF.md
# Column Command Latency Scheduler

This block sits beside a double-data-rate memory controller's command path. Each accepted column command is a read or a write, given with a starting column, a burst length and an ordering. The block waits out the programmed latency for that command and then opens a data window of the right length. A read window marks the clocks in which returning data is valid. A write window marks the clocks in which the controller must put write data, strobes and byte masks on the bus.

Latency is programmed as a CAS latency plus an additive (posted) latency. Read latency is their sum, and write latency is one clock less. Data moves at two beats per clock, so each window clock reports the column index of its even beat and of its odd beat in the chosen burst order. During writes it also reports the two mask bits for those beats. The burst settings and the latency are captured with each command. Commands that follow each other closely travel through a shift pipeline, so every command gets its own window at its own time. An illegal latency setting raises an error flag, and any command presented while the setting is illegal is dropped.

Top module: `dq_window_sched`

## Requirements
- R1: The setting is legal when `cfg_cl` is 3..6 and `cfg_al` is 0..5. `cfg_err` shows, one clock later, whether the setting sampled on the previous edge was illegal. A command presented while the setting is illegal produces no window.
- R2: A read command is presented in cycle c with read latency RL = cfg_cl + cfg_al. `rd_valid` is high from cycle c+RL onward.
- R3: A write command presented in cycle c drives `wr_valid` high from cycle c+RL-1 onward.
- R4: A window lasts 2 clocks when `cfg_bl8`=0 (4 beats) and 4 clocks when `cfg_bl8`=1 (8 beats). In window clock k, the even beat is number 2k and the odd beat is number 2k+1.
- R5: With `cfg_ilv`=0 (sequential), beat b of an 8-beat burst has column (col+b) mod 8. For a 4-beat burst, bit 2 of the column is kept and the low two bits are (col+b) mod 4.
- R6: With `cfg_ilv`=1 (interleaved), beat b has column col XOR b.
- R7: During a write window, `wr_mask` equals {cmd_mask[2k+1], cmd_mask[2k]} for window clock k. Bit i of `cmd_mask` masks transferred beat i. At all other times `wr_mask` is 0.
- R8: Commands may be issued on consecutive-enough cycles while earlier ones are still waiting, and each gets its own window. If a new window of the same direction opens while an older one is still running, the new one replaces the old one from that clock on.
- R9: After reset, `rd_valid`, `wr_valid`, `wr_mask` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl | input | 3 | CAS latency in clocks |
| cfg_al | input | 3 | Additive latency in clocks |
| cfg_bl8 | input | 1 | 1: 8-beat burst, 0: 4-beat burst |
| cfg_ilv | input | 1 | 1: interleaved order, 0: sequential |
| cmd_valid | input | 1 | Column command present this cycle |
| cmd_wr | input | 1 | 1: write, 0: read |
| cmd_col | input | 3 | Starting column low bits |
| cmd_mask | input | 8 | Per-beat write mask, bit i for beat i |
| cfg_err | output | 1 | Latency setting illegal |
| rd_valid | output | 1 | Read data window |
| rd_col0 | output | 3 | Column of the even read beat this clock |
| rd_col1 | output | 3 | Column of the odd read beat this clock |
| wr_valid | output | 1 | Write data window |
| wr_col0 | output | 3 | Column of the even write beat this clock |
| wr_col1 | output | 3 | Column of the odd write beat this clock |
| wr_mask | output | 2 | Mask for {odd, even} write beat |

## Verification
Every legal latency pair is swept against both directions, both burst lengths, both orders and all eight starting columns. The sweep separates a window placed one clock early or late from a correct one, a read that picks up the write latency from one that does not, a wrap across the 4-beat boundary from one across the 8-beat boundary, and additive order from XOR order. A mixed sequence brings out independent read and write windows that overlap in time. The same sequence also shows a restart, where a read window opens while another read window is still running. Illegal latency pairs just outside each bound check both the flag and that the command is dropped.

// File: rtl/dws_pkg.sv
package dws_pkg;
  localparam int CFG_W  = 3;
  localparam int COL_W  = 3;
  localparam int BEATS  = 8;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int CNT_W  = BEAT_W - 1;
  localparam int STG_W  = 4;

  typedef struct packed {
    logic [COL_W-1:0] col;
    logic             bl8;
    logic             ilv;
    logic [BEATS-1:0] mask;
  } dws_launch_t;

  typedef struct packed {
    logic              valid;
    logic              is_wr;
    logic [STG_W-1:0]  fire_at;
    dws_launch_t       info;
  } dws_tok_t;

  function automatic logic lat_legal(input logic [CFG_W-1:0] cl,
                                     input logic [CFG_W-1:0] al,
                                     input int min_cl, input int max_cl,
                                     input int max_al);
    return (int'(cl) >= min_cl) && (int'(cl) <= max_cl) && (int'(al) <= max_al);
  endfunction

  // stage index (1-based) in which the token must be seen so the window
  // is registered open exactly when the latency expires
  function automatic logic [STG_W-1:0] fire_stage(input logic [CFG_W-1:0] cl,
                                                  input logic [CFG_W-1:0] al,
                                                  input logic is_wr);
    logic [STG_W-1:0] rl;
    rl = STG_W'(cl) + STG_W'(al);
    return is_wr ? rl - STG_W'(2) : rl - STG_W'(1);
  endfunction

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] col,
                                                input logic bl8, input logic ilv,
                                                input logic [BEAT_W-1:0] beat);
    logic [COL_W-1:0] sum;
    sum = col + COL_W'(beat);
    if (ilv)      return col ^ COL_W'(beat);
    else if (bl8) return sum;
    else          return {col[COL_W-1], sum[COL_W-2:0]};
  endfunction
endpackage

// File: rtl/dws_cmd_pipe.sv
module dws_cmd_pipe import dws_pkg::*; #(
  parameter int DEPTH = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  dws_tok_t    in_tok,
  output logic        rd_fire,
  output dws_launch_t rd_info,
  output logic        wr_fire,
  output dws_launch_t wr_info
);
  dws_tok_t stg_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= in_tok;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  // stage i holds a token accepted i+1 clocks ago; older tokens win a tie
  always_comb begin
    rd_fire = 1'b0;
    wr_fire = 1'b0;
    rd_info = '0;
    wr_info = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (stg_q[i].valid && stg_q[i].fire_at == STG_W'(i + 1)) begin
        if (stg_q[i].is_wr) begin
          wr_fire = 1'b1;
          wr_info = stg_q[i].info;
        end else begin
          rd_fire = 1'b1;
          rd_info = stg_q[i].info;
        end
      end
    end
  end
endmodule

// File: rtl/dws_burst_engine.sv
module dws_burst_engine import dws_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  dws_launch_t      lin,
  output logic             active,
  output logic [COL_W-1:0] col_a,
  output logic [COL_W-1:0] col_b,
  output logic [1:0]       mask_pair
);
  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  dws_launch_t      cur_q;
  logic [BEAT_W-1:0] beat_e;
  logic [BEAT_W-1:0] beat_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
      cur_q  <= '0;
    end else if (fire) begin
      act_q  <= 1'b1;
      cnt_q  <= '0;
      last_q <= lin.bl8 ? CNT_W'(BEATS/2 - 1) : CNT_W'(1);
      cur_q  <= lin;
    end else if (act_q) begin
      if (cnt_q == last_q) act_q <= 1'b0;
      else                 cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign beat_e    = {cnt_q, 1'b0};
  assign beat_o    = {cnt_q, 1'b1};
  assign active    = act_q;
  assign col_a     = beat_col(cur_q.col, cur_q.bl8, cur_q.ilv, beat_e);
  assign col_b     = beat_col(cur_q.col, cur_q.bl8, cur_q.ilv, beat_o);
  assign mask_pair = act_q ? {cur_q.mask[beat_o], cur_q.mask[beat_e]} : 2'b00;
endmodule

// File: rtl/dq_window_sched.sv
module dq_window_sched import dws_pkg::*; #(
  parameter int MIN_CL = 3,
  parameter int MAX_CL = 6,
  parameter int MAX_AL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_cl,
  input  logic [CFG_W-1:0] cfg_al,
  input  logic             cfg_bl8,
  input  logic             cfg_ilv,
  input  logic             cmd_valid,
  input  logic             cmd_wr,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [BEATS-1:0] cmd_mask,
  output logic             cfg_err,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col0,
  output logic [COL_W-1:0] rd_col1,
  output logic             wr_valid,
  output logic [COL_W-1:0] wr_col0,
  output logic [COL_W-1:0] wr_col1,
  output logic [1:0]       wr_mask
);
  localparam int DEPTH = MAX_CL + MAX_AL - 1;
  localparam int NENG  = 2;

  logic        cfg_ok;
  logic        cmd_accept;
  logic        cfg_err_q;
  dws_tok_t    new_tok;
  logic        rd_fire;
  logic        wr_fire;
  dws_launch_t rd_info;
  dws_launch_t wr_info;

  logic             eng_fire [NENG];
  dws_launch_t      eng_info [NENG];
  logic             eng_act  [NENG];
  logic [COL_W-1:0] eng_c0   [NENG];
  logic [COL_W-1:0] eng_c1   [NENG];
  logic [1:0]       eng_mask [NENG];

  assign cfg_ok     = lat_legal(cfg_cl, cfg_al, MIN_CL, MAX_CL, MAX_AL);
  assign cmd_accept = cmd_valid && cfg_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err_q <= 1'b0;
    else        cfg_err_q <= !cfg_ok;
  end
  assign cfg_err = cfg_err_q;

  always_comb begin
    new_tok           = '0;
    new_tok.valid     = cmd_accept;
    new_tok.is_wr     = cmd_wr;
    new_tok.fire_at   = fire_stage(cfg_cl, cfg_al, cmd_wr);
    new_tok.info.col  = cmd_col;
    new_tok.info.bl8  = cfg_bl8;
    new_tok.info.ilv  = cfg_ilv;
    new_tok.info.mask = cmd_wr ? cmd_mask : '0;
  end

  dws_cmd_pipe #(.DEPTH(DEPTH)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_tok  (new_tok),
    .rd_fire (rd_fire),
    .rd_info (rd_info),
    .wr_fire (wr_fire),
    .wr_info (wr_info)
  );

  assign eng_fire[0] = rd_fire;
  assign eng_info[0] = rd_info;
  assign eng_fire[1] = wr_fire;
  assign eng_info[1] = wr_info;

  for (genvar g = 0; g < NENG; g++) begin : g_eng
    dws_burst_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (eng_fire[g]),
      .lin       (eng_info[g]),
      .active    (eng_act[g]),
      .col_a     (eng_c0[g]),
      .col_b     (eng_c1[g]),
      .mask_pair (eng_mask[g])
    );
  end

  assign rd_valid = eng_act[0];
  assign rd_col0  = eng_c0[0];
  assign rd_col1  = eng_c1[0];
  assign wr_valid = eng_act[1];
  assign wr_col0  = eng_c0[1];
  assign wr_col1  = eng_c1[1];
  // read tokens carry an all-zero mask, so the read engine adds nothing here
  assign wr_mask  = eng_mask[1] | eng_mask[0];
endmodule

// File: rtl/dws_check.sv
module dws_check import dws_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_cl,
  input logic [CFG_W-1:0] cfg_al,
  input logic             cmd_valid,
  input logic             cmd_accept,
  input logic             cfg_err,
  input logic             rd_fire,
  input logic             wr_fire,
  input logic             rd_valid,
  input logic [COL_W-1:0] rd_col0,
  input logic [COL_W-1:0] rd_col1,
  input logic             wr_valid,
  input logic [COL_W-1:0] wr_col0,
  input logic [COL_W-1:0] wr_col1,
  input logic [1:0]       wr_mask
);
  logic bad_cfg;
  assign bad_cfg = (cfg_cl < 3'd3) || (cfg_cl > 3'd6) || (cfg_al > 3'd5);

  AST_BAD_CFG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && bad_cfg) |-> !cmd_accept); // R1
  AST_CFG_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cfg |=> cfg_err); // R1
  AST_CFG_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_cfg |=> !cfg_err); // R1
  AST_RD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid); // R2
  AST_WR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> wr_valid); // R3
  AST_RD_BEATS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_col0 != rd_col1)); // R5
  AST_WR_BEATS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_col0 != wr_col1)); // R6
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (wr_mask == 2'b00)); // R7
endmodule

bind dq_window_sched dws_check u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_cl     (cfg_cl),
  .cfg_al     (cfg_al),
  .cmd_valid  (cmd_valid),
  .cmd_accept (cmd_accept),
  .cfg_err    (cfg_err),
  .rd_fire    (rd_fire),
  .wr_fire    (wr_fire),
  .rd_valid   (rd_valid),
  .rd_col0    (rd_col0),
  .rd_col1    (rd_col1),
  .wr_valid   (wr_valid),
  .wr_col0    (wr_col0),
  .wr_col1    (wr_col1),
  .wr_mask    (wr_mask)
);

// File: tb/dq_window_sched_test.sv
module dq_window_sched_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_cl = 3'd3;
  logic [2:0] cfg_al = 3'd0;
  logic       cfg_bl8 = 1'b0;
  logic       cfg_ilv = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [2:0] cmd_col = 3'd0;
  logic [7:0] cmd_mask = 8'd0;
  logic       cfg_err;
  logic       rd_valid, wr_valid;
  logic [2:0] rd_col0, rd_col1, wr_col0, wr_col1;
  logic [1:0] wr_mask;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  string tag_ovr = "";

  int   n_cmd = 0;
  int   q_t   [8];
  bit   q_wr  [8];
  int   q_col [8];
  bit   q_bl8 [8];
  bit   q_ilv [8];
  int   q_mask[8];

  always #10 clk = ~clk;

  dq_window_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
    .cfg_bl8(cfg_bl8), .cfg_ilv(cfg_ilv), .cmd_valid(cmd_valid),
    .cmd_wr(cmd_wr), .cmd_col(cmd_col), .cmd_mask(cmd_mask),
    .cfg_err(cfg_err), .rd_valid(rd_valid), .rd_col0(rd_col0),
    .rd_col1(rd_col1), .wr_valid(wr_valid), .wr_col0(wr_col0),
    .wr_col1(wr_col1), .wr_mask(wr_mask)
  );

  task automatic chk(input string tag, input int act, input int exp);
    string t;
    t = (tag_ovr != "") ? tag_ovr : tag;
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", t, act, exp, $time);
    end
  endtask

  function automatic int model_col(input int col, input bit bl8, input bit ilv, input int b);
    if (ilv) return col ^ b;
    if (bl8) return (col + b) % 8;
    return (col / 4) * 4 + (col + b) % 4;
  endfunction

  task automatic add_cmd(input int t, input bit wr, input int col, input bit bl8,
                         input bit ilv, input int mask);
    q_t[n_cmd] = t; q_wr[n_cmd] = wr; q_col[n_cmd] = col;
    q_bl8[n_cmd] = bl8; q_ilv[n_cmd] = ilv; q_mask[n_cmd] = mask;
    n_cmd++;
  endtask

  // j: cycles since edge E0 (outputs as left by edge E_j)
  task automatic check_cycle(input int j, input int cl, input int al);
    bit ok;
    ok = (cl >= 3) && (cl <= 6) && (al <= 5);
    for (int d = 0; d < 2; d++) begin
      bit ev; int ec0, ec1, em; bit eilv;
      ev = 0; ec0 = 0; ec1 = 0; em = 0; eilv = 0;
      for (int c = 0; c < n_cmd; c++) begin
        if (ok && int'(q_wr[c]) == d) begin
          int lat, nclk, k;
          lat  = cl + al - d;
          nclk = q_bl8[c] ? 4 : 2;
          k    = j - q_t[c] - (lat - 1);
          if (k >= 0 && k < nclk) begin
            ev = 1; eilv = q_ilv[c];
            ec0 = model_col(q_col[c], q_bl8[c], q_ilv[c], 2*k);
            ec1 = model_col(q_col[c], q_bl8[c], q_ilv[c], 2*k + 1);
            em  = (q_mask[c] >> (2*k)) & 3;
          end
        end
      end
      if (d == 0) begin
        chk("R2,R4 rd_valid", int'(rd_valid), int'(ev));
        if (ev) begin
          chk(eilv ? "R6 rd_col0" : "R5 rd_col0", int'(rd_col0), ec0);
          chk(eilv ? "R6 rd_col1" : "R5 rd_col1", int'(rd_col1), ec1);
        end
      end else begin
        chk("R3,R4 wr_valid", int'(wr_valid), int'(ev));
        chk("R7 wr_mask", int'(wr_mask), ev ? em : 0);
        if (ev) begin
          chk(eilv ? "R6 wr_col0" : "R5 wr_col0", int'(wr_col0), ec0);
          chk(eilv ? "R6 wr_col1" : "R5 wr_col1", int'(wr_col1), ec1);
        end
      end
    end
  endtask

  task automatic run_batch(input int cl, input int al, input int span);
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (i > 0) check_cycle(i - 1, cl, al);
      cmd_valid = 1'b0;
      for (int c = 0; c < n_cmd; c++) begin
        if (q_t[c] == i) begin
          cmd_valid = 1'b1; cmd_wr = q_wr[c]; cmd_col = 3'(q_col[c]);
          cfg_bl8 = q_bl8[c]; cfg_ilv = q_ilv[c]; cmd_mask = 8'(q_mask[c]);
        end
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    n_cmd = 0;
  endtask

  task automatic set_cfg(input int cl, input int al);
    @(negedge clk);
    cfg_cl = 3'(cl); cfg_al = 3'(al);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired before the run completed");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 rd_valid", int'(rd_valid), 0);
    chk("R9 wr_valid", int'(wr_valid), 0);
    chk("R9 wr_mask", int'(wr_mask), 0);
    chk("R9 cfg_err", int'(cfg_err), 0);

    // full sweep of single commands
    for (int cl = 3; cl <= 6; cl++)
      for (int al = 0; al <= 5; al++) begin
        set_cfg(cl, al);
        for (int wr = 0; wr < 2; wr++)
          for (int bl = 0; bl < 2; bl++)
            for (int il = 0; il < 2; il++)
              for (int col = 0; col < 8; col++) begin
                add_cmd(0, bit'(wr), col, bit'(bl), bit'(il), (col * 37 + cl * 11 + al) & 255);
                run_batch(cl, al, 18);
              end
      end

    // R1 illegal settings: flag rises, commands dropped
    tag_ovr = "R1";
    begin
      int bad_cl[5] = '{2, 7, 0, 3, 6};
      int bad_al[5] = '{0, 1, 0, 6, 7};
      for (int b = 0; b < 5; b++) begin
        set_cfg(bad_cl[b], bad_al[b]);
        @(negedge clk);
        chk("R1 cfg_err", int'(cfg_err), 1);
        add_cmd(0, 1'b0, 2, 1'b1, 1'b0, 0);
        add_cmd(1, 1'b1, 5, 1'b1, 1'b1, 255);
        run_batch(bad_cl[b], bad_al[b], 20);
      end
      set_cfg(3, 0);
      @(negedge clk);
      chk("R1 cfg_err clear", int'(cfg_err), 0);
      set_cfg(6, 5);
      @(negedge clk);
      chk("R1 cfg_err clear", int'(cfg_err), 0);
    end

    // R8 queued commands with overlapping latencies
    tag_ovr = "R8";
    set_cfg(5, 2);
    add_cmd(0, 1'b0, 1, 1'b0, 1'b0, 0);
    add_cmd(2, 1'b0, 6, 1'b0, 1'b1, 0);
    add_cmd(4, 1'b1, 3, 1'b1, 1'b0, 8'hA5);
    add_cmd(8, 1'b0, 7, 1'b1, 1'b0, 0);
    run_batch(5, 2, 24);
    // R8 restart of a running read window
    set_cfg(3, 0);
    add_cmd(0, 1'b0, 0, 1'b1, 1'b0, 0);
    add_cmd(2, 1'b0, 5, 1'b0, 1'b0, 0);
    add_cmd(3, 1'b1, 6, 1'b1, 1'b1, 8'h3C);
    run_batch(3, 0, 14);
    tag_ovr = "";

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule